// File: doc/BRIEF.md
# Halted-Core Instruction Injector over JTAG

This unit drives a JTAG port (TCK, TMS, TDI, TDO) to push instruction words into the pipeline of a processor core that has stopped in debug state. Each request carries a 32-bit instruction word and a speed flag. The flag tells the core whether the following instruction runs at full system speed (1) or at debug speed (0). Before the first injection, the unit points the TAP at the instruction-injection chain (chain 1) with the internal-test instruction loaded. It caches that selection and reuses it for every later request. It then scans a 33-bit frame and walks the TAP through Run-Test/Idle, which moves the instruction into the pipeline. The unit returns the 32 bits the chain captured from the core's data bus during that same scan.

When a request repeats the previous word and flag exactly, the scan would change nothing in the chain. In that case the unit gives a single TCK pulse in Run-Test/Idle, which still advances the pipeline. A request can also ask for a no-operation word. The unit then picks the 32-bit-mode or the 16-bit-mode encoding according to the core's instruction-set state bit, which the caller supplies. A caller that knows another agent has selected a different scan chain pulses the invalidate input. Both caches are then forgotten.

Top module: `jinj_top`

## Requirements
- R1: After reset the unit is busy, holds TCK low, and gives six TCK pulses: five with TMS high and one with TMS low. This leaves the TAP in Run-Test/Idle. It then drops busy.
- R2: The first injection after reset or invalidation selects the chain before the frame. It loads IR code 4'b0010 (chain select), shifts chain number 4'd1 into the DR, and loads IR code 4'b1100 (internal test). Every IR and chain-number field is shifted LSB first. Between these three scans the TAP goes from each Update state straight to Select-DR-Scan and never enters Run-Test/Idle. The whole transaction takes 64 TCK pulses.
- R3: The frame is 33 bits. The speed flag is shifted first, followed by the instruction word MSB first. The scan leaves Shift-DR through Update-DR and ends in Run-Test/Idle.
- R4: rdata_o holds the TDO bits sampled during the 32 instruction bits of the frame. The first of those bits becomes bit 31. done_o is a one-cycle pulse, and rdata_o is valid from that pulse onward.
- R5: While the selection is cached, a changed request performs the frame scan only: 38 TCK pulses with no IR scan.
- R6: A request whose resulting word and flag both equal the last scanned ones gives exactly one TCK pulse with TMS low and no DR scan. It then pulses done_o with rdata_o equal to 0.
- R7: A request with the same word but a different flag performs a full frame scan.
- R8: With req_nop_i high, the injected word is 32'hE1A00000 when tbit_i is 0 and 32'h46C046C0 when tbit_i is 1. The repeat check of R6 compares this resulting word.
- R9: A pulse on sel_lost_i clears the chain selection and the repeat cache, so the next request performs the full path of R2. If the pulse arrives in the same cycle as an accepted request, that request already takes the full path.
- R10: Requests presented while busy_o is high are ignored. They cause no scan, no done pulse and no change to the repeat cache.
- R11: Each TCK high phase lasts TCK_HALF clock cycles. TMS and TDI change only while TCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when the unit is not busy |
| req_nop_i | input | 1 | Inject the no-operation word instead of req_instr_i |
| req_instr_i | input | 32 | Instruction word to inject |
| req_sysspd_i | input | 1 | Speed flag: 1 system speed, 0 debug speed |
| tbit_i | input | 1 | Core instruction-set state: 1 selects the 16-bit no-op |
| sel_lost_i | input | 1 | Another chain was selected; drop both caches |
| busy_o | output | 1 | Reset walk or injection in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Data-bus word captured by the last frame |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to the target |
| tdo_i | input | 1 | JTAG data from the target |

## Verification
Two functions can collide in one cycle: the invalidation of the caches and the repeat decision for a newly accepted request. The bench first injects a word, then presents the identical word while pulsing sel_lost_i in the very cycle of acceptance. It judges the result by the TCK count and the TAP path seen in its own TAP model. A skip would show one pulse, while the correct result shows the 64-pulse path with a fresh chain selection. A second case runs the same request with the invalidation pulsed alone while idle, so the two paths can be compared.

// File: rtl/jinj_pkg.sv
package jinj_pkg;

  localparam int WORD_W  = 32;
  localparam int FRAME_W = WORD_W + 1;
  localparam int IR_W    = 4;
  localparam int CHAIN_W = 4;
  localparam int RST_LEN = 6;

  typedef enum logic [2:0] {
    PH_INIT, PH_IDLE, PH_SCANN, PH_CHAIN, PH_INTEST, PH_FRAME, PH_TICK
  } phase_t;

  typedef enum logic [1:0] {E_REST, E_LOW, E_HIGH} edge_t;

  // Navigation length from Run-Test/Idle or Update-xR into Shift-xR.
  function automatic int hdr_len(input logic is_ir);
    return is_ir ? 4 : 3;
  endfunction

  // TCK pulses for one scan: navigation, data bits, Update, optional Idle.
  function automatic int scan_len(input logic is_ir, input int n, input logic end_idle);
    return hdr_len(is_ir) + n + 1 + (end_idle ? 1 : 0);
  endfunction

  // {tms, tdi} for pulse k of a scan; data[0] is shifted first.
  function automatic logic [1:0] scan_step(input logic is_ir, input int n,
                                           input logic [FRAME_W-1:0] data, input int k);
    int h;
    logic [1:0] r;
    h = hdr_len(is_ir);
    r = 2'b00;
    if (k < h) begin
      r[1] = (k == 0) || (is_ir && k == 1);
    end else if (k < h + n) begin
      r[1] = (k == h + n - 1);
      for (int i = 0; i < FRAME_W; i++)
        if (i == k - h) r[0] = data[i];
    end else if (k == h + n) begin
      r = 2'b10;
    end
    return r;
  endfunction

  // Injection frame in shift order: speed flag, then the word MSB first.
  function automatic logic [FRAME_W-1:0] frame_bits(input logic flag, input logic [WORD_W-1:0] w);
    logic [FRAME_W-1:0] f;
    f[0] = flag;
    for (int i = 0; i < WORD_W; i++) f[1+i] = w[WORD_W-1-i];
    return f;
  endfunction

endpackage

// File: rtl/jinj_tck_engine.sv
module jinj_tck_engine
  import jinj_pkg::*;
#(
  parameter int TCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_valid_i,
  input  logic step_tms_i,
  input  logic step_tdi_i,
  input  logic tdo_i,
  output logic step_ready_o,
  output logic step_fin_o,
  output logic tdo_smp_o,
  output logic tck_o,
  output logic tms_o,
  output logic tdi_o
);

  localparam int CW = $clog2(TCK_HALF + 1);

  edge_t         st;
  logic [CW-1:0] cnt;
  logic          half_end;

  assign half_end     = (cnt == CW'(TCK_HALF - 1));
  assign step_ready_o = (st == E_REST);
  assign step_fin_o   = (st == E_HIGH) && half_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_REST;
      cnt       <= '0;
      tck_o     <= 1'b0;
      tms_o     <= 1'b1;
      tdi_o     <= 1'b0;
      tdo_smp_o <= 1'b0;
    end else begin
      unique case (st)
        E_REST: if (step_valid_i) begin
          tms_o <= step_tms_i;
          tdi_o <= step_tdi_i;
          cnt   <= '0;
          st    <= E_LOW;
        end
        E_LOW: if (half_end) begin
          tck_o     <= 1'b1;
          tdo_smp_o <= tdo_i;
          cnt       <= '0;
          st        <= E_HIGH;
        end else cnt <= cnt + 1'b1;
        E_HIGH: if (half_end) begin
          tck_o <= 1'b0;
          cnt   <= '0;
          st    <= E_REST;
        end else cnt <= cnt + 1'b1;
        default: st <= E_REST;
      endcase
    end
  end

  AST_PINS_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tck_o |-> ($stable(tms_o) && $stable(tdi_o))); // R11

  AST_FIN_RETURNS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_fin_o |=> (!tck_o && step_ready_o)); // R11

endmodule

// File: rtl/jinj_word_sel.sv
module jinj_word_sel
  import jinj_pkg::*;
#(
  parameter logic [WORD_W-1:0] NOP_WIDE   = 32'hE1A0_0000,
  parameter logic [WORD_W-1:0] NOP_NARROW = 32'h46C0_46C0
) (
  input  logic              nop_i,
  input  logic              tbit_i,
  input  logic [WORD_W-1:0] instr_i,
  output logic [WORD_W-1:0] word_o
);

  function automatic logic [WORD_W-1:0] pick(input logic nop, input logic narrow,
                                             input logic [WORD_W-1:0] w);
    if (!nop) return w;
    return narrow ? NOP_NARROW : NOP_WIDE;
  endfunction

  assign word_o = pick(nop_i, tbit_i, instr_i);

endmodule

// File: rtl/jinj_cache.sv
module jinj_cache
  import jinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lost_i,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] commit_word_i,
  input  logic              commit_flag_i,
  input  logic [WORD_W-1:0] q_word_i,
  input  logic              q_flag_i,
  output logic              sel_ok_o,
  output logic              hit_o
);

  logic              sel_q;
  logic              last_v;
  logic [WORD_W-1:0] last_w;
  logic              last_f;

  // Same-cycle invalidation takes priority over the stored selection.
  assign sel_ok_o = sel_q && !lost_i;
  assign hit_o    = sel_ok_o && last_v && (q_word_i == last_w) && (q_flag_i == last_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      last_v <= 1'b0;
      last_w <= '0;
      last_f <= 1'b0;
    end else if (lost_i) begin
      sel_q  <= 1'b0;
      last_v <= 1'b0;
    end else if (commit_i) begin
      sel_q  <= 1'b1;
      last_v <= 1'b1;
      last_w <= commit_word_i;
      last_f <= commit_flag_i;
    end
  end

  AST_LOST_DROPS_SELECTION: assert property (@(posedge clk) disable iff (!rst_n)
    lost_i |=> !sel_ok_o); // R9

endmodule

// File: rtl/jinj_seq.sv
module jinj_seq
  import jinj_pkg::*;
#(
  parameter logic [IR_W-1:0]    IR_SCAN_N = 4'b0010,
  parameter logic [IR_W-1:0]    IR_INTEST = 4'b1100,
  parameter logic [CHAIN_W-1:0] CHAIN_SEL = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              flag_i,
  input  logic              hit_i,
  input  logic              sel_ok_i,
  input  logic              step_ready_i,
  input  logic              step_fin_i,
  input  logic              tdo_smp_i,
  output logic              step_valid_o,
  output logic              step_tms_o,
  output logic              step_tdi_o,
  output logic              commit_o,
  output logic [WORD_W-1:0] lat_word_o,
  output logic              lat_flag_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int K_W = $clog2(FRAME_W + 8);

  phase_t             ph;
  phase_t             next_ph;
  logic [K_W-1:0]     k_q;
  logic               pend;
  logic [WORD_W-1:0]  cap;
  logic               sc_ir;
  logic               sc_idle;
  int                 sc_n;
  logic [FRAME_W-1:0] sc_data;
  int                 step_len;
  logic               last_step;
  logic               in_word;
  logic               accept;
  logic               tick_end;
  logic               frame_end;

  // Scan parameters of the current phase.
  always_comb begin
    sc_ir   = 1'b0;
    sc_idle = 1'b0;
    sc_n    = 0;
    sc_data = '0;
    unique case (ph)
      PH_SCANN:  begin sc_ir = 1'b1; sc_n = IR_W;    sc_data[IR_W-1:0]    = IR_SCAN_N; end
      PH_CHAIN:  begin               sc_n = CHAIN_W; sc_data[CHAIN_W-1:0] = CHAIN_SEL; end
      PH_INTEST: begin sc_ir = 1'b1; sc_n = IR_W;    sc_data[IR_W-1:0]    = IR_INTEST; end
      PH_FRAME:  begin sc_idle = 1'b1; sc_n = FRAME_W;
                       sc_data = frame_bits(lat_flag_o, lat_word_o); end
      default: ;
    endcase
  end

  always_comb begin
    step_len   = 0;
    step_tms_o = 1'b0;
    step_tdi_o = 1'b0;
    if (ph == PH_INIT) begin
      step_len   = RST_LEN;
      step_tms_o = (int'(k_q) < RST_LEN - 1);
    end else if (ph == PH_TICK) begin
      step_len = 1;
    end else begin
      step_len = scan_len(sc_ir, sc_n, sc_idle);
      {step_tms_o, step_tdi_o} = scan_step(sc_ir, sc_n, sc_data, int'(k_q));
    end
  end

  always_comb begin
    unique case (ph)
      PH_INIT:   next_ph = PH_IDLE;
      PH_SCANN:  next_ph = PH_CHAIN;
      PH_CHAIN:  next_ph = PH_INTEST;
      PH_INTEST: next_ph = PH_FRAME;
      default:   next_ph = PH_IDLE;
    endcase
  end

  assign last_step    = (int'(k_q) == step_len - 1);
  assign in_word      = (ph == PH_FRAME) && (int'(k_q) > hdr_len(1'b0))
                        && (int'(k_q) <= hdr_len(1'b0) + WORD_W);
  assign busy_o       = (ph != PH_IDLE);
  assign step_valid_o = busy_o && !pend && step_ready_i;
  assign accept       = (ph == PH_IDLE) && req_valid_i;
  assign tick_end     = (ph == PH_TICK) && step_fin_i && pend;
  assign frame_end    = (ph == PH_FRAME) && step_fin_i && pend && last_step;
  assign commit_o     = frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_INIT;
      k_q        <= '0;
      pend       <= 1'b0;
      lat_word_o <= '0;
      lat_flag_o <= 1'b0;
      cap        <= '0;
      done_o     <= 1'b0;
      rdata_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (step_valid_o) pend <= 1'b1;
      if (accept) begin
        lat_word_o <= word_i;
        lat_flag_o <= flag_i;
        k_q        <= '0;
        cap        <= '0;
        ph         <= hit_i ? PH_TICK : (sel_ok_i ? PH_FRAME : PH_SCANN);
      end
      if (step_fin_i && pend) begin
        pend <= 1'b0;
        if (in_word) cap <= {cap[WORD_W-2:0], tdo_smp_i};
        if (last_step) begin
          k_q <= '0;
          ph  <= next_ph;
          if (ph == PH_FRAME) begin done_o <= 1'b1; rdata_o <= cap; end
          if (ph == PH_TICK)  begin done_o <= 1'b1; rdata_o <= '0;  end
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4

  AST_TICK_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TICK && step_valid_o) |-> !step_tms_o); // R6

  AST_TICK_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick_end |=> (done_o && rdata_o == '0)); // R6

  AST_BUSY_ONLY_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_valid_i)); // R10

endmodule

// File: rtl/jinj_top.sv
module jinj_top
  import jinj_pkg::*;
#(
  parameter int                 TCK_HALF   = 2,
  parameter logic [IR_W-1:0]    IR_SCAN_N  = 4'b0010,
  parameter logic [IR_W-1:0]    IR_INTEST  = 4'b1100,
  parameter logic [CHAIN_W-1:0] CHAIN_SEL  = 4'd1,
  parameter logic [WORD_W-1:0]  NOP_WIDE   = 32'hE1A0_0000,
  parameter logic [WORD_W-1:0]  NOP_NARROW = 32'h46C0_46C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_nop_i,
  input  logic [WORD_W-1:0] req_instr_i,
  input  logic              req_sysspd_i,
  input  logic              tbit_i,
  input  logic              sel_lost_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] lat_word;
  logic              lat_flag;
  logic              hit, sel_ok, commit;
  logic              step_valid, step_tms, step_tdi;
  logic              step_ready, step_fin, tdo_smp;

  jinj_word_sel #(.NOP_WIDE(NOP_WIDE), .NOP_NARROW(NOP_NARROW)) u_word (
    .nop_i(req_nop_i), .tbit_i(tbit_i), .instr_i(req_instr_i), .word_o(word));

  jinj_cache u_cache (
    .clk(clk), .rst_n(rst_n), .lost_i(sel_lost_i), .commit_i(commit),
    .commit_word_i(lat_word), .commit_flag_i(lat_flag),
    .q_word_i(word), .q_flag_i(req_sysspd_i), .sel_ok_o(sel_ok), .hit_o(hit));

  jinj_seq #(.IR_SCAN_N(IR_SCAN_N), .IR_INTEST(IR_INTEST), .CHAIN_SEL(CHAIN_SEL)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .word_i(word),
    .flag_i(req_sysspd_i), .hit_i(hit), .sel_ok_i(sel_ok),
    .step_ready_i(step_ready), .step_fin_i(step_fin), .tdo_smp_i(tdo_smp),
    .step_valid_o(step_valid), .step_tms_o(step_tms), .step_tdi_o(step_tdi),
    .commit_o(commit), .lat_word_o(lat_word), .lat_flag_o(lat_flag),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o));

  jinj_tck_engine #(.TCK_HALF(TCK_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .step_valid_i(step_valid), .step_tms_i(step_tms),
    .step_tdi_i(step_tdi), .tdo_i(tdo_i), .step_ready_o(step_ready),
    .step_fin_o(step_fin), .tdo_smp_o(tdo_smp), .tck_o(tck_o), .tms_o(tms_o),
    .tdi_o(tdi_o));

endmodule

// File: tb/jinj_top_test.sv
module jinj_top_test;

  localparam int HALF = 2;

  typedef enum logic [3:0] {
    TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR, SIR, CIR, SHI, E1I, PIR, E2I, UIR
  } tap_t;

  typedef struct {
    int          kind;      // 0 select+frame, 1 frame only, 2 single tick
    logic [32:0] frame;
    logic [31:0] rdata;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_nop = 1'b0, req_spd = 1'b0, tbit = 1'b0, lost = 1'b0;
  logic [31:0] req_instr = '0;
  logic        busy, done, tck, tms, tdi;
  logic        tdo = 1'b0;
  logic [31:0] rdata;

  int checks = 0, fails = 0, dones = 0, pushes = 0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  jinj_top #(.TCK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_nop_i(req_nop),
    .req_instr_i(req_instr), .req_sysspd_i(req_spd), .tbit_i(tbit), .sel_lost_i(lost),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .tck_o(tck), .tms_o(tms),
    .tdi_o(tdi), .tdo_i(tdo));

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // ---------------- behavioural TAP target ----------------
  tap_t        st = TLR;
  logic [3:0]  ir = 4'b1110, ir_sr = '0, chain = '0, sc_sr = '0;
  logic [32:0] sr = '0, bus_cap = '0, frame_sr = '0;
  logic        in_sel = 1'b0;
  int tck_total = 0, scann_cnt = 0, frame_cnt = 0, idle_sel_cnt = 0;

  function automatic tap_t nxt(input tap_t s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;  RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;  CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;  E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;  E2D: return m ? UDR : SHD;
      UDR: return m ? SDR : RTI;  SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;  SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;  PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;  default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    tck_total++;
    if (st == RTI && in_sel) idle_sel_cnt++;
    case (st)
      TLR: ir = 4'b1110;
      SHI: ir_sr = {tdi, ir_sr[3:1]};
      UIR: begin
        ir = ir_sr;
        if (ir_sr == 4'b0010) begin in_sel = 1'b1; scann_cnt++; end
        if (ir_sr == 4'b1100) in_sel = 1'b0;
      end
      CDR: if (ir == 4'b1100 && chain == 4'd1) sr = bus_cap;
      SHD: begin
        if (ir == 4'b0010) sc_sr = {tdi, sc_sr[3:1]};
        if (ir == 4'b1100 && chain == 4'd1) sr = {tdi, sr[32:1]};
      end
      UDR: begin
        if (ir == 4'b0010) chain = sc_sr;
        if (ir == 4'b1100 && chain == 4'd1) begin frame_sr = sr; frame_cnt++; end
      end
      default: ;
    endcase
    st = nxt(st, tms);
  end

  always @(negedge tck)
    tdo <= (st == SHD && ir == 4'b1100 && chain == 4'd1) ? sr[0] : 1'b0;

  // ---------------- monitor / scoreboard ----------------
  int  b_tck = 0, b_scan = 0, b_frame = 0, b_idle = 0, hi_run = 0, bad_hi = 0, hi_seen = 0;
  bit  init_done = 1'b0;

  always @(negedge clk) begin
    if (tck) hi_run++;
    else if (hi_run != 0) begin
      hi_seen++;
      if (hi_run != HALF) bad_hi++;
      hi_run = 0;
    end
    if (rst_n && !init_done && !busy) begin
      chk("R1 reset walk pulses", 64'(tck_total), 64'd6);
      chk("R1 TAP in Run-Test/Idle", 64'(st), 64'(RTI));
      b_tck = tck_total; b_scan = scann_cnt; b_frame = frame_cnt; b_idle = idle_sel_cnt;
      init_done = 1'b1;
    end
    if (rst_n && done) begin
      item_t it;
      dones++;
      if (exp_q.size() == 0) chk("R10 unexpected done", 64'd1, 64'd0);
      else begin
        it = exp_q.pop_front();
        chk({it.tag, " rdata"}, 64'(rdata), 64'(it.rdata));
        // pulses: select = 9 + 8 + 9 + frame 38; frame = 3 + 33 + 1 + 1; tick = 1
        chk({it.tag, " tck count"}, 64'(tck_total - b_tck),
            64'(it.kind == 0 ? 64 : (it.kind == 1 ? 38 : 1)));
        chk({it.tag, " frames"}, 64'(frame_cnt - b_frame), 64'(it.kind == 2 ? 0 : 1));
        if (it.kind != 2) chk({it.tag, " frame bits R3"}, 64'(frame_sr), 64'(it.frame));
        chk({it.tag, " chain selects R2"}, 64'(scann_cnt - b_scan), 64'(it.kind == 0 ? 1 : 0));
        if (it.kind == 0) begin
          chk({it.tag, " chain number R2"}, 64'(chain), 64'd1);
          chk({it.tag, " no idle inside selection R2"}, 64'(idle_sel_cnt - b_idle), 64'd0);
        end
        chk({it.tag, " ends in idle"}, 64'(st), 64'(RTI));
      end
      b_tck = tck_total; b_scan = scann_cnt; b_frame = frame_cnt; b_idle = idle_sel_cnt;
    end
  end

  // ---------------- driver ----------------
  bit          c_sel = 1'b0, c_lv = 1'b0, c_lf = 1'b0;
  logic [31:0] c_lw = '0, seed = 32'h1234_5678;

  task automatic issue(input bit nop, input logic [31:0] ins, input bit flag, input bit tb,
                       input bit lost_same, input string tag);
    item_t       it;
    logic [31:0] w;
    @(negedge clk);
    while (busy) @(negedge clk);
    w = nop ? (tb ? 32'h46C046C0 : 32'hE1A00000) : ins;
    if (lost_same) begin c_sel = 1'b0; c_lv = 1'b0; end
    it.kind = (c_sel && c_lv && w == c_lw && flag == c_lf) ? 2 : (c_sel ? 1 : 0);
    seed = seed * 32'd1103515245 + 32'd12345;
    bus_cap = {seed[9], seed ^ 32'hA5C3_0F69};
    it.frame[0] = flag;
    for (int j = 0; j < 32; j++) it.frame[32-j] = w[j];
    for (int j = 0; j < 32; j++) it.rdata[j] = (it.kind == 2) ? 1'b0 : bus_cap[32-j];
    it.tag = tag;
    if (it.kind != 2) begin c_sel = 1'b1; c_lv = 1'b1; c_lw = w; c_lf = flag; end
    exp_q.push_back(it);
    pushes++;
    req_valid = 1'b1; req_nop = nop; req_instr = ins; req_spd = flag; tbit = tb;
    lost = lost_same;
    @(negedge clk);
    req_valid = 1'b0; lost = 1'b0;
  endtask

  task automatic drop_selection();
    @(negedge clk);
    while (busy) @(negedge clk);
    lost = 1'b1;
    @(negedge clk);
    lost = 1'b0;
    c_sel = 1'b0; c_lv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tck low in reset", 64'(tck), 64'd0);
    chk("R1 done low in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd1);
    while (!init_done) @(negedge clk);

    issue(0, 32'h1234_5678, 0, 0, 0, "R2 R3 R4 first injection");
    issue(0, 32'hE59F_0010, 1, 0, 0, "R5 cached selection");
    issue(0, 32'hE59F_0010, 1, 0, 0, "R6 repeat skipped");
    issue(0, 32'hE59F_0010, 0, 0, 0, "R7 flag change rescans");
    issue(1, 32'h0BAD_F00D, 0, 0, 0, "R8 wide no-op");
    issue(0, 32'hE1A0_0000, 0, 1, 0, "R8 wide no-op literal repeat");
    issue(1, 32'h0BAD_F00D, 0, 1, 0, "R8 narrow no-op");
    issue(0, 32'h46C0_46C0, 0, 0, 0, "R8 narrow no-op literal repeat");
    drop_selection();
    issue(0, 32'h46C0_46C0, 0, 0, 0, "R9 invalidated while idle");
    issue(0, 32'h46C0_46C0, 0, 0, 1, "R9 invalidated in accept cycle");
    issue(0, 32'hCAFE_0001, 1, 0, 0, "R10 request before busy burst");
    req_valid = 1'b1; req_instr = 32'hDEAD_BEEF; req_spd = 1'b0;   // ignored: busy
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    issue(0, 32'hCAFE_0001, 1, 0, 0, "R10 cache untouched by ignored request");
    issue(0, 32'h8000_0001, 0, 0, 0, "R3 R4 edge bits");

    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 done pulses equal requests", 64'(dones), 64'(pushes));
    chk("R11 tck high phase length", 64'(bad_hi), 64'd0);
    chk("R11 tck activity seen", 64'(hi_seen > 0), 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule